// File: doc/BRIEF.md
# Frame-counted SPI master controller

This block is an SPI master with a small register port. Each transfer moves a
programmed number of frames in one direction only. Software picks the direction,
the frame width (1 to 16 bits), the bit order, the clock mode (0 to 3) and the
clock divider. It then loads a frame count. In transmit mode the block takes
words from a shared 64-entry FIFO and shifts them out on MOSI. In receive mode
nothing happens until software writes any value to the data register. After that
write, frames are sampled from MISO and pushed into the same FIFO, and software
pops them by reading the data register.

The frame counter goes down by one after each completed frame and can be read
back at any time. When it reaches zero the block raises an end-of-transfer flag.
Setting a clock-inhibit bit holds the block at the next frame boundary without
losing the current frame. A FIFO threshold flag and the end-of-transfer flag
each latch a pending event. Each pending event can drive the interrupt line
through its own enable bit. Chip select is driven outside the block.

Top module: `spi_frm_master`

## Requirements
- R1: After reset the status word reads 0x1 (FIFO empty only), the frame count reads 0 and irq_o is low.
- R2: Each SCK half-period lasts R+1 clk_i cycles, where R is control bits 6:0.
- R3: A frame is N+1 bits long, where N is control bits 12:9 (for example 7 gives 8 bits and 11 gives 12 bits).
- R4: Control bit 19 set sends and receives MSB first. Cleared, LSB goes first.
- R5: Control bits 17:16 hold the clock mode: bit 17 is the SCK idle level and bit 16 selects sampling on the trailing edge. SCK rests at its idle level whenever no frame is shifting.
- R6: With control bit 15 = 1, frames are taken from the FIFO in write order and shifted out. The frame count (offset 0x08) drops by one per completed frame.
- R7: With control bit 15 = 0, no clocking starts until the data register (0x14) is written. Received frames are then pushed into the FIFO, and each data-register read pops one frame in arrival order.
- R8: Setting control bit 13 stops new frames from starting. A frame already in flight completes, and clearing the bit resumes the transfer.
- R9: Status (0x10) bit 0 is FIFO empty, bit 2 is FIFO full and bit 3 is busy (a frame is shifting).
- R10: Status bit 7 is set when the frame count reaches zero. irq_o follows this event while enable bit 1 (0x0C) is set. Writing 1 to status bit 8 clears both pending events and the end-of-transfer bit.
- R11: Status bit 1 is the threshold flag. Its level is 16 entries with control bit 14 = 0, or 32 entries with control bit 14 = 1. Transmit mode flags fill <= level, and receive mode flags fill >= level. A rise of the flag is latched as pending and drives irq_o while enable bit 0 is set.
- R12: A data write to a full FIFO is dropped. A data read from an empty FIFO returns 0 and changes nothing.
- R13: Global register (0x00) bit 0 must be set for any frame to start. While bit 1 is set, the FIFO is flushed and the shifter returns to idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Reference clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_re_i | input | 1 | Register read strobe (a data read pops) |
| reg_addr_i | input | 8 | Byte offset of the register |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data for the addressed register |
| sck_o | output | 1 | SPI clock |
| mosi_o | output | 1 | Serial data out |
| miso_i | input | 1 | Serial data in |
| irq_o | output | 1 | Level interrupt |

## Verification
In a receive transfer, the final frame does two things at once. Its completion
pushes the FIFO to the threshold level, and in that same cycle it takes the
frame count to zero. The bench sets up this overlap with a 16-frame read, a
threshold level of 16 and both interrupt enables set. It then expects the status
word to show the threshold and end-of-transfer bits together, with irq_o high.
It also expects the 16 popped words to match the slave pattern in order, and a
single clear write to drop the interrupt.

// File: rtl/spi_frm_pkg.sv
package spi_frm_pkg;
  localparam int          RATE_W    = 7;
  localparam logic [7:0]  OFS_GLB   = 8'h00;
  localparam logic [7:0]  OFS_CTL   = 8'h04;
  localparam logic [7:0]  OFS_FRM   = 8'h08;
  localparam logic [7:0]  OFS_IER   = 8'h0C;
  localparam logic [7:0]  OFS_STAT  = 8'h10;
  localparam logic [7:0]  OFS_DAT   = 8'h14;
  localparam logic [31:0] CTL_MASK  = 32'h000B_FEFF;
  localparam int CTL_MASTER  = 7;
  localparam int CTL_LEN_LSB = 9;
  localparam int CTL_INHIBIT = 13;
  localparam int CTL_THR     = 14;
  localparam int CTL_DIR     = 15;
  localparam int CTL_CPHA    = 16;
  localparam int CTL_CPOL    = 17;
  localparam int CTL_MSB     = 19;
  localparam int STAT_INTCLR = 8;
endpackage

// File: rtl/spi_frm_fifo.sv
module spi_frm_fifo #(
  parameter int DW    = 16,
  parameter int DEPTH = 64,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic          push_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          pop_i,
  output logic [DW-1:0] rdata_o,
  output logic [AW:0]   count_o,
  output logic          empty_o,
  output logic          full_o
);
  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic          do_push, do_pop;

  assign empty_o = (count_o == '0);
  assign full_o  = (count_o == (AW+1)'(DEPTH));
  assign do_push = push_i && !full_o;
  assign do_pop  = pop_i && !empty_o;
  assign rdata_o = mem[rp];

  always_ff @(posedge clk_i) begin
    if (do_push) mem[wp] <= wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wp <= '0; rp <= '0; count_o <= '0;
    end else if (clr_i) begin
      wp <= '0; rp <= '0; count_o <= '0;
    end else begin
      if (do_push) wp <= wp + 1'b1;
      if (do_pop)  rp <= rp + 1'b1;
      if (do_push && !do_pop)      count_o <= count_o + 1'b1;
      else if (do_pop && !do_push) count_o <= count_o - 1'b1;
    end
  end
endmodule

// File: rtl/spi_frm_engine.sv
module spi_frm_engine import spi_frm_pkg::*; #(
  parameter int LEN_W = 4,
  localparam int DW   = 1 << LEN_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              start_i,
  input  logic [DW-1:0]     tx_word_i,
  input  logic [LEN_W-1:0]  bitsm1_i,
  input  logic [RATE_W-1:0] rate_i,
  input  logic              cpol_i,
  input  logic              cpha_i,
  input  logic              msb_i,
  input  logic              miso_i,
  output logic              active_o,
  output logic              done_o,
  output logic [DW-1:0]     rx_word_o,
  output logic              sck_o,
  output logic              mosi_o
);
  logic [RATE_W-1:0] div_q;
  logic [LEN_W:0]    edge_q;
  logic              sck_q;
  logic [DW-1:0]     tx_sh, rx_sh;
  logic [LEN_W-1:0]  algn;
  logic              tick, lead, smp, lch;

  assign algn  = ~bitsm1_i;  // DW-1 minus bitsm1
  assign tick  = active_o && (div_q == rate_i);
  assign lead  = ~edge_q[0];
  assign smp   = tick && (lead ^ cpha_i);
  assign lch   = tick && (lead == cpha_i) && (edge_q != '0);

  assign sck_o     = active_o ? sck_q : cpol_i;
  assign mosi_o    = msb_i ? tx_sh[DW-1] : tx_sh[0];
  assign rx_word_o = msb_i ? rx_sh : (rx_sh >> algn);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_o <= 1'b0; done_o <= 1'b0; div_q <= '0; edge_q <= '0;
      sck_q <= 1'b0; tx_sh <= '0; rx_sh <= '0;
    end else begin
      done_o <= 1'b0;
      if (clr_i) begin
        active_o <= 1'b0;
      end else if (start_i && !active_o) begin
        active_o <= 1'b1;
        div_q    <= '0;
        edge_q   <= '0;
        sck_q    <= cpol_i;
        tx_sh    <= msb_i ? (tx_word_i << algn) : tx_word_i;
        rx_sh    <= '0;
      end else if (active_o) begin
        if (tick) begin
          div_q  <= '0;
          sck_q  <= ~sck_q;
          edge_q <= edge_q + 1'b1;
          if (smp) rx_sh <= msb_i ? {rx_sh[DW-2:0], miso_i} : {miso_i, rx_sh[DW-1:1]};
          if (lch) tx_sh <= msb_i ? (tx_sh << 1) : (tx_sh >> 1);
          if (edge_q == {bitsm1_i, 1'b1}) begin
            active_o <= 1'b0;
            done_o   <= 1'b1;
          end
        end else begin
          div_q <= div_q + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/spi_frm_master.sv
module spi_frm_master import spi_frm_pkg::*; #(
  parameter int LEN_W = 4,
  parameter int DEPTH = 64,
  parameter int FRM_W = 16
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        reg_we_i,
  input  logic        reg_re_i,
  input  logic [7:0]  reg_addr_i,
  input  logic [31:0] reg_wdata_i,
  output logic [31:0] reg_rdata_o,
  output logic        sck_o,
  output logic        mosi_o,
  input  logic        miso_i,
  output logic        irq_o
);
  localparam int DW = 1 << LEN_W;
  localparam int AW = $clog2(DEPTH);
  localparam logic [AW:0] LVL_LO = (AW+1)'(DEPTH / 4);
  localparam logic [AW:0] LVL_HI = (AW+1)'(DEPTH / 2);

  logic             glb_on, glb_srst;
  logic [31:0]      ctl_q;
  logic [FRM_W-1:0] frm_cnt;
  logic [1:0]       ier_q;
  logic             eot_q, thr_pend, thr_prev, rx_run;
  logic             wr_glb, wr_ctl, wr_frm, wr_ier, wr_dat, rd_dat, intclr;
  logic             dir, inhibit, thr_flag, start;
  logic             eng_active, eng_done;
  logic [DW-1:0]    rx_word, fifo_rdata;
  logic [AW:0]      fifo_cnt;
  logic             fifo_empty, fifo_full;

  assign wr_glb = reg_we_i && (reg_addr_i == OFS_GLB);
  assign wr_ctl = reg_we_i && (reg_addr_i == OFS_CTL);
  assign wr_frm = reg_we_i && (reg_addr_i == OFS_FRM);
  assign wr_ier = reg_we_i && (reg_addr_i == OFS_IER);
  assign wr_dat = reg_we_i && (reg_addr_i == OFS_DAT);
  assign intclr = reg_we_i && (reg_addr_i == OFS_STAT) && reg_wdata_i[STAT_INTCLR];
  assign rd_dat = reg_re_i && (reg_addr_i == OFS_DAT);

  assign dir      = ctl_q[CTL_DIR];
  assign inhibit  = ctl_q[CTL_INHIBIT];
  assign thr_flag = dir ? (fifo_cnt <= (ctl_q[CTL_THR] ? LVL_HI : LVL_LO))
                        : (fifo_cnt >= (ctl_q[CTL_THR] ? LVL_HI : LVL_LO));
  assign start    = glb_on && !glb_srst && ctl_q[CTL_MASTER] && !inhibit &&
                    !eng_active && !eng_done && (frm_cnt != '0) &&
                    (dir ? !fifo_empty : (rx_run && !fifo_full));
  assign irq_o    = (eot_q && ier_q[1]) || (thr_pend && ier_q[0]);

  spi_frm_fifo #(.DW(DW), .DEPTH(DEPTH)) u_fifo (
    .clk_i, .rst_ni, .clr_i(glb_srst),
    .push_i (dir ? wr_dat : eng_done),
    .wdata_i(dir ? reg_wdata_i[DW-1:0] : rx_word),
    .pop_i  (dir ? start : rd_dat),
    .rdata_o(fifo_rdata), .count_o(fifo_cnt),
    .empty_o(fifo_empty), .full_o(fifo_full)
  );

  spi_frm_engine #(.LEN_W(LEN_W)) u_eng (
    .clk_i, .rst_ni, .clr_i(glb_srst), .start_i(start),
    .tx_word_i(fifo_rdata), .bitsm1_i(ctl_q[CTL_LEN_LSB +: LEN_W]),
    .rate_i(ctl_q[RATE_W-1:0]), .cpol_i(ctl_q[CTL_CPOL]), .cpha_i(ctl_q[CTL_CPHA]),
    .msb_i(ctl_q[CTL_MSB]), .miso_i, .active_o(eng_active), .done_o(eng_done),
    .rx_word_o(rx_word), .sck_o, .mosi_o
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      glb_on <= 1'b0; glb_srst <= 1'b0; ctl_q <= '0; frm_cnt <= '0; ier_q <= '0;
      eot_q <= 1'b0; thr_pend <= 1'b0; thr_prev <= 1'b0; rx_run <= 1'b0;
    end else begin
      if (wr_glb) begin
        glb_on   <= reg_wdata_i[0];
        glb_srst <= reg_wdata_i[1];
      end
      if (wr_ctl) ctl_q <= reg_wdata_i & CTL_MASK;
      if (wr_ier) ier_q <= reg_wdata_i[1:0];

      if (wr_frm)                         frm_cnt <= reg_wdata_i[FRM_W-1:0];
      else if (eng_done && frm_cnt != '0) frm_cnt <= frm_cnt - 1'b1;

      // dummy data write arms a receive transfer
      if (glb_srst || wr_frm || (eng_done && frm_cnt == FRM_W'(1))) rx_run <= 1'b0;
      else if (wr_dat && !dir && frm_cnt != '0)                     rx_run <= 1'b1;

      if (glb_srst || intclr || wr_frm)             eot_q <= 1'b0;
      else if (eng_done && frm_cnt == FRM_W'(1))    eot_q <= 1'b1;

      thr_prev <= thr_flag;
      if (thr_flag && !thr_prev && !glb_srst)       thr_pend <= 1'b1;
      else if (glb_srst || intclr)                  thr_pend <= 1'b0;
    end
  end

  always_comb begin
    reg_rdata_o = '0;
    unique case (reg_addr_i)
      OFS_GLB:  reg_rdata_o = {30'd0, glb_srst, glb_on};
      OFS_CTL:  reg_rdata_o = ctl_q;
      OFS_FRM:  reg_rdata_o = {{(32-FRM_W){1'b0}}, frm_cnt};
      OFS_IER:  reg_rdata_o = {30'd0, ier_q};
      OFS_STAT: reg_rdata_o = {24'd0, eot_q, 3'd0, eng_active, fifo_full, thr_flag, fifo_empty};
      OFS_DAT:  reg_rdata_o = fifo_empty ? 32'd0 : {{(32-DW){1'b0}}, fifo_rdata};
      default:  reg_rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/spi_frm_master_chk.sv
module spi_frm_master_chk #(
  parameter int FRM_W = 16,
  parameter int CW    = 7,
  parameter int DEPTH = 64
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             eng_active,
  input logic             eng_done,
  input logic [FRM_W-1:0] frm_cnt,
  input logic             wr_frm,
  input logic             inhibit,
  input logic             irq_o,
  input logic             intclr,
  input logic             wr_ier,
  input logic             glb_srst,
  input logic [CW-1:0]    fifo_cnt,
  input logic             fifo_full,
  input logic             fifo_empty
);
  p_frm_dec_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (eng_done && !wr_frm && frm_cnt != '0) |=> (frm_cnt == $past(frm_cnt) - 1'b1));

  p_done_pulse_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eng_done |=> !eng_done);

  p_inhibit_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (inhibit && !eng_active) |=> !eng_active);

  p_irq_sticky_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_o && !intclr && !wr_ier && !glb_srst) |=> irq_o);

  p_no_overflow_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fifo_cnt <= CW'(DEPTH));

  p_full_empty_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(fifo_full && fifo_empty));
endmodule

bind spi_frm_master spi_frm_master_chk #(.FRM_W(FRM_W), .CW(AW+1), .DEPTH(DEPTH)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .eng_active(eng_active), .eng_done(eng_done),
  .frm_cnt(frm_cnt), .wr_frm(wr_frm), .inhibit(inhibit), .irq_o(irq_o),
  .intclr(intclr), .wr_ier(wr_ier), .glb_srst(glb_srst), .fifo_cnt(fifo_cnt),
  .fifo_full(fifo_full), .fifo_empty(fifo_empty)
);

// File: tb/tb_spi_frm_master.sv
module tb_spi_frm_master;
  timeunit 1ns; timeprecision 1ps;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        we = 1'b0, re = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        sck, mosi, miso, irq;

  always #2.5 clk = ~clk;

  spi_frm_master dut (
    .clk_i(clk), .rst_ni(rst_n), .reg_we_i(we), .reg_re_i(re), .reg_addr_i(addr),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata), .sck_o(sck), .mosi_o(mosi),
    .miso_i(miso), .irq_o(irq)
  );

  int n_chk = 0, n_bad = 0;
  bit finished = 0;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  // scoreboard
  logic [15:0] exp_q[$];
  bit          mon_en = 0;
  int          mon_bits = 8;
  bit          mon_msb = 1;
  int          mb_cnt = 0;
  logic [15:0] mb_acc = '0;
  logic        sck_prev = 1'b0;

  // slave model: pattern indexed by count of SCK falls
  logic [127:0] slv_pat = '0;
  int           slv_idx = 0;
  int           slv_base = 0;
  int           slv_pos;
  assign slv_pos = 127 - (slv_idx - slv_base);
  assign miso = (slv_pos >= 0 && slv_pos <= 127) ? slv_pat[slv_pos] : 1'b0;

  always @(negedge clk) begin
    if (!sck && sck_prev) slv_idx <= slv_idx + 1;
    if (mon_en && sck && !sck_prev) begin
      logic [15:0] acc_n;
      logic [15:0] msk;
      logic [15:0] e;
      acc_n = mb_acc;
      if (mon_msb) acc_n = {mb_acc[14:0], mosi};
      else         acc_n[mb_cnt] = mosi;
      if (mb_cnt + 1 == mon_bits) begin
        msk = 16'((32'd1 << mon_bits) - 1);
        if (exp_q.size() == 0) chk(0, "R6 unexpected frame", {16'd0, acc_n & msk}, 32'd0);
        else begin
          e = exp_q.pop_front();
          chk((acc_n & msk) == (e & msk), "R6/R3/R4 tx frame", {16'd0, acc_n & msk}, {16'd0, e & msk});
        end
        mb_cnt <= 0; mb_acc <= '0;
      end else begin
        mb_cnt <= mb_cnt + 1; mb_acc <= acc_n;
      end
    end
    sck_prev <= sck;
  end

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); we = 1'b1; addr = a; wdata = d;
    @(negedge clk); we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk); re = 1'b1; addr = a;
    #1 d = rdata;
    @(negedge clk); re = 1'b0;
  endtask

  task automatic push(input logic [15:0] w, input bit expect_it);
    wr(8'h14, {16'd0, w});
    if (expect_it) exp_q.push_back(w);
  endtask

  task automatic wait_eot(input string tag);
    logic [31:0] s;
    bit seen = 0;
    for (int i = 0; i < 5000; i++) begin
      rd(8'h10, s);
      if (s[7]) begin seen = 1; break; end
    end
    chk(seen, {tag, " end-of-transfer reached"}, {31'd0, seen}, 32'd1);
  endtask

  task automatic set_mode(input logic [31:0] ctl, input int bits, input bit msb);
    mon_en = 0;
    wr(8'h04, ctl);
    @(negedge clk);
    mon_bits = bits; mon_msb = msb; mb_cnt = 0; mb_acc = '0;
    mon_en = 1;
  endtask

  initial begin
    #600us;
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    realtime t0, t1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R1 reset state
    rd(8'h10, d); chk(d == 32'h1, "R1 status after reset", d, 32'h1);
    rd(8'h08, d); chk(d == 32'h0, "R1 frame count after reset", d, 32'h0);
    chk(irq == 1'b0, "R1 irq after reset", {31'd0, irq}, 32'd0);

    // tx, mode 0, MSB first, 8 bits, R=2
    wr(8'h00, 32'h1);
    wr(8'h0C, 32'h2);
    set_mode(32'h0008_8E82, 8, 1);
    push(16'hA5, 1); push(16'h3C, 1); push(16'h81, 1);
    rd(8'h10, d); chk(d == 32'h2, "R9/R11 status with 3 queued", d, 32'h2);
    wr(8'h08, 32'd3);
    do @(negedge clk); while (!sck);
    t0 = $realtime;
    do @(negedge clk); while (sck);
    t1 = $realtime;
    chk((t1 - t0) == 15.0, "R2 half period R=2", 32'(int'(t1 - t0)), 32'd15);
    wait_eot("R10");
    rd(8'h08, d); chk(d == 32'h0, "R6 frame count drained", d, 32'h0);
    rd(8'h10, d); chk(d == 32'h83, "R10 status at end", d, 32'h83);
    chk(irq == 1'b1, "R10 irq on eot", {31'd0, irq}, 32'd1);
    wr(8'h10, 32'h100);
    chk(irq == 1'b0, "R10 irq cleared", {31'd0, irq}, 32'd0);
    rd(8'h10, d); chk(d == 32'h3, "R10 eot bit cleared", d, 32'h3);
    chk(exp_q.size() == 0, "R6 all frames sent", exp_q.size(), 32'd0);

    // tx, mode 3, LSB first, 12 bits, R=0
    set_mode(32'h0003_9680, 12, 0);
    chk(sck == 1'b1, "R5 idle level mode 3", {31'd0, sck}, 32'd1);
    push(16'h0A5C, 1); push(16'h03F1, 1);
    wr(8'h08, 32'd2);
    wait_eot("R3/R4");
    chk(sck == 1'b1, "R5 idle after frames", {31'd0, sck}, 32'd1);
    chk(exp_q.size() == 0, "R4 all lsb frames sent", exp_q.size(), 32'd0);
    wr(8'h10, 32'h100);

    // R8 inhibit at frame boundary
    set_mode(32'h0008_8E81, 8, 1);
    push(16'h11, 1); push(16'h22, 1);
    wr(8'h08, 32'd2);
    do rd(8'h10, d); while (!d[3]);
    wr(8'h04, 32'h0008_AE81);
    repeat (100) @(negedge clk);
    rd(8'h08, d); chk(d == 32'h1, "R8 paused after one frame", d, 32'h1);
    rd(8'h10, d); chk(d[3] == 1'b0, "R8 not busy while inhibited", {31'd0, d[3]}, 32'd0);
    wr(8'h04, 32'h0008_8E81);
    wait_eot("R8");
    chk(exp_q.size() == 0, "R8 resumed and finished", exp_q.size(), 32'd0);
    wr(8'h10, 32'h100);

    // R7 receive, threshold and eot together (R11)
    mon_en = 0;
    wr(8'h04, 32'h0008_0E80);
    wr(8'h10, 32'h100);
    wr(8'h0C, 32'h3);
    for (int k = 0; k < 16; k++) begin
      logic [7:0] b;
      b = 8'(k * 29 + 7);
      slv_pat[127 - 8*k -: 8] = b;
      exp_q.push_back({8'd0, b});
    end
    slv_base = slv_idx;
    wr(8'h08, 32'd16);
    repeat (20) @(negedge clk);
    rd(8'h08, d); chk(d == 32'd16, "R7 no clocking before dummy write", d, 32'd16);
    chk(irq == 1'b0, "R11 no irq before transfer", {31'd0, irq}, 32'd0);
    wr(8'h14, 32'h0);
    wait_eot("R7");
    rd(8'h10, d); chk(d == 32'h82, "R11 threshold and eot together", d, 32'h82);
    chk(irq == 1'b1, "R11 irq raised", {31'd0, irq}, 32'd1);
    for (int k = 0; k < 16; k++) begin
      logic [15:0] e;
      e = exp_q.pop_front();
      rd(8'h14, d);
      chk(d == {16'd0, e}, "R7 received frame", d, {16'd0, e});
    end
    rd(8'h10, d); chk(d == 32'h81, "R9 empty after pops", d, 32'h81);
    wr(8'h10, 32'h100);
    chk(irq == 1'b0, "R11 irq cleared", {31'd0, irq}, 32'd0);

    // R12 empty read and full write
    rd(8'h14, d); chk(d == 32'h0, "R12 empty read returns 0", d, 32'h0);
    rd(8'h10, d); chk(d == 32'h1, "R12 empty read changes nothing", d, 32'h1);
    set_mode(32'h0008_8E80, 8, 1);
    for (int i = 0; i < 65; i++) push(16'(8'(i * 3 + 1)), i < 64);
    rd(8'h10, d); chk(d == 32'h4, "R9/R12 full flag", d, 32'h4);
    wr(8'h08, 32'd64);
    wait_eot("R12");
    rd(8'h10, d); chk(d == 32'h83, "R12 extra word was dropped", d, 32'h83);
    chk(exp_q.size() == 0, "R12 64 frames sent", exp_q.size(), 32'd0);
    wr(8'h10, 32'h100);

    // R13 soft reset flush, global enable
    push(16'h77, 0); push(16'h78, 0); push(16'h79, 0);
    rd(8'h10, d); chk(d == 32'h2, "R13 queued before flush", d, 32'h2);
    wr(8'h00, 32'h3);
    wr(8'h00, 32'h1);
    rd(8'h10, d); chk(d == 32'h3, "R13 flushed by soft reset", d, 32'h3);
    wr(8'h00, 32'h0);
    push(16'h5A, 1);
    wr(8'h08, 32'd1);
    repeat (40) @(negedge clk);
    rd(8'h08, d); chk(d == 32'h1, "R13 no frame while off", d, 32'h1);
    wr(8'h00, 32'h1);
    wait_eot("R13");
    rd(8'h08, d); chk(d == 32'h0, "R13 frame after enable", d, 32'h0);
    chk(exp_q.size() == 0, "R13 frame content", exp_q.size(), 32'd0);

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule